// File: doc/BRIEF.md
# Banked Data RAM Address Generator with Register Shadow

This block places a 1 KB byte-wide data RAM behind a 128-byte processor window. A 3-bit bank register provides the upper RAM address bits for ordinary data accesses, so software reaches all eight 128-byte banks by changing the bank and then using the window. The bank register is itself one of the register-space locations. Only its low three bits are kept, and the upper bits read back as zero.

When the processor accesses register space, the block ignores the bank register and forces the upper address bits to the shadow bank, 6. Every register write therefore also lands in the shadow bank. A register that has no read path of its own can then be read back through register space, or as ordinary data with the bank set to 6. Registers that do have a read path return their live value instead. The block also raises a write strobe for the external sensor registers, but only when bank 0 is selected.

The RAM is synchronous and is modelled inside the block. Read data and its valid flag appear one clock after the read request.

Top module: `bkram_shadow`

## Requirements
- R1: After a synchronous active-low reset, `bank_sel` is 0 and `rdata_vld` is 0.
- R2: When `reg_acc` is 0, `ram_addr` equals `{bank_sel, cpu_addr}` in the same cycle.
- R3: When `reg_acc` is 1, `ram_addr[9:7]` is 6 whatever the bank register holds, and `ram_addr[6:0]` equals `cpu_addr`.
- R4: A register-space write to window offset 0x7B loads `cpu_wdata[2:0]` into the bank register. It takes effect from the next cycle, and `cpu_wdata[7:3]` is ignored. A register-space read of 0x7B returns `{5'b0, bank}`.
- R5: Every write stores `cpu_wdata` at the RAM byte given by `ram_addr`. A register write therefore lands in bank 6, and a data write lands only in the selected bank; all other bytes stay unchanged.
- R6: A register-space read of any offset other than 0x7B with `reg_has_rd` = 0 returns the shadow byte at `{6, cpu_addr}`. With `reg_has_rd` = 1 it returns `reg_rdata` as sampled on the read edge.
- R7: `sens_wr` is 1 exactly when `cpu_wr` and `reg_acc` are 1, the bank register holds 0, and `cpu_addr` is not 0x7B.
- R8: `rdata_vld` is 1 in the cycle after a cycle with `cpu_rd` = 1 and is 0 otherwise. `cpu_rdata` is valid while `rdata_vld` is 1.
- R9: When a read and a write fall in the same cycle, the read returns the state from before the write. This holds for RAM bytes and for the bank register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 7 | Offset inside the 128-byte window |
| cpu_wdata | input | 8 | Write data |
| cpu_wr | input | 1 | Write request |
| cpu_rd | input | 1 | Read request |
| reg_acc | input | 1 | Access targets register space |
| reg_has_rd | input | 1 | Addressed register has its own read path |
| reg_rdata | input | 8 | Live value of that register |
| cpu_rdata | output | 8 | Read data |
| rdata_vld | output | 1 | Read data valid |
| ram_addr | output | 10 | Generated RAM address |
| bank_sel | output | 3 | Current bank register |
| sens_wr | output | 1 | Sensor register write strobe |

## Verification
`ram_addr` and `sens_wr` are combinational, so the bench checks them one time unit after it drives the inputs, before the clock edge. `cpu_rdata` and `rdata_vld` come from one register stage (the RAM output and the read-source capture). The bench checks them one time unit after the edge that samples the read, against a model that computes the read result before it applies that edge's writes. A bank-register write is reflected in `bank_sel` and `ram_addr` only from the following cycle, and the model applies it at the same point.

// File: rtl/bkram_pkg.sv
// Shared types for the banked RAM block.
// Assumes: read-source codes are used only inside this block.
package bkram_pkg;
    typedef enum logic [1:0] {
        SRC_RAM  = 2'd0,
        SRC_EXT  = 2'd1,
        SRC_BANK = 2'd2
    } rd_src_e;
endpackage

// File: rtl/bkram_bank_reg.sv
// Bank select register. It holds the upper RAM address bits for data accesses.
// Assumes: the register is loaded only by a register-space write to BANK_REG_ADDR,
// and only the low BANK_W data bits are stored.
module bkram_bank_reg #(
    parameter int ADDR_W        = 7,
    parameter int BANK_W        = 3,
    parameter int DATA_W        = 8,
    parameter int BANK_REG_ADDR = 'h7B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              reg_acc,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [BANK_W-1:0] bank
);
    localparam logic [ADDR_W-1:0] BANK_ADDR_L = ADDR_W'(BANK_REG_ADDR);

    logic load;
    assign load = wr && reg_acc && (addr == BANK_ADDR_L);

    // Purpose: reset the bank to 0, or take the low data bits on a load.
    always_ff @(posedge clk) begin
        if (!rst_n)    bank <= '0;
        else if (load) bank <= wdata[BANK_W-1:0];
    end

    AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (bank == $past(wdata[BANK_W-1:0]))); // R4
    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(bank)); // R4
endmodule

// File: rtl/bkram_addr_gen.sv
// Address generator. It builds the RAM address from the bank and the window
// offset, forces the shadow bank in register space, and gates the sensor strobe.
// Assumes: the RAM write enable follows every processor write.
module bkram_addr_gen #(
    parameter int ADDR_W        = 7,
    parameter int BANK_W        = 3,
    parameter int SHADOW_BANK   = 6,
    parameter int SENSOR_BANK   = 0,
    parameter int BANK_REG_ADDR = 'h7B
) (
    input  logic                     reg_acc,
    input  logic                     wr,
    input  logic [BANK_W-1:0]        bank,
    input  logic [ADDR_W-1:0]        addr,
    output logic [BANK_W+ADDR_W-1:0] ram_addr,
    output logic                     mem_we,
    output logic                     sens_wr
);
    localparam logic [BANK_W-1:0] SHADOW_L    = BANK_W'(SHADOW_BANK);
    localparam logic [BANK_W-1:0] SENSOR_L    = BANK_W'(SENSOR_BANK);
    localparam logic [ADDR_W-1:0] BANK_ADDR_L = ADDR_W'(BANK_REG_ADDR);

    logic [BANK_W-1:0] hi_bits;

    // Purpose: pick the upper bits; register space always uses the shadow bank.
    always_comb begin
        hi_bits = reg_acc ? SHADOW_L : bank;
    end

    // Purpose: form the RAM address, the RAM write enable and the sensor strobe.
    always_comb begin
        ram_addr = {hi_bits, addr};
        mem_we   = wr;
        sens_wr  = wr && reg_acc && (bank == SENSOR_L) && (addr != BANK_ADDR_L);
    end
endmodule

// File: rtl/bkram_mem.sv
// Synchronous single-port byte RAM.
// Assumes: read-first behaviour. A read returns the old byte when a write to
// the same address happens in the same cycle.
module bkram_mem #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    // Purpose: registered read of the old contents, then the write.
    always_ff @(posedge clk) begin
        if (re) q <= store[addr];
        if (we) store[addr] <= wdata;
    end
endmodule

// File: rtl/bkram_shadow.sv
// Top level: banked data RAM with a register-write shadow bank.
// Assumes: cpu_rd and cpu_wr are single-cycle requests. reg_rdata is valid in
// the cycle of the read request.
module bkram_shadow
    import bkram_pkg::*;
#(
    parameter int ADDR_W        = 7,
    parameter int BANK_W        = 3,
    parameter int DATA_W        = 8,
    parameter int SHADOW_BANK   = 6,
    parameter int SENSOR_BANK   = 0,
    parameter int BANK_REG_ADDR = 'h7B
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        cpu_addr,
    input  logic [DATA_W-1:0]        cpu_wdata,
    input  logic                     cpu_wr,
    input  logic                     cpu_rd,
    input  logic                     reg_acc,
    input  logic                     reg_has_rd,
    input  logic [DATA_W-1:0]        reg_rdata,
    output logic [DATA_W-1:0]        cpu_rdata,
    output logic                     rdata_vld,
    output logic [BANK_W+ADDR_W-1:0] ram_addr,
    output logic [BANK_W-1:0]        bank_sel,
    output logic                     sens_wr
);
    localparam int RAM_AW = BANK_W + ADDR_W;
    localparam logic [ADDR_W-1:0] BANK_ADDR_L = ADDR_W'(BANK_REG_ADDR);
    localparam logic [BANK_W-1:0] SHADOW_L    = BANK_W'(SHADOW_BANK);
    localparam logic [BANK_W-1:0] SENSOR_L    = BANK_W'(SENSOR_BANK);

    logic              mem_we;
    logic [DATA_W-1:0] mem_q;
    rd_src_e           src_d, src_q;
    logic [DATA_W-1:0] ext_q;
    logic [BANK_W-1:0] bank_q;

    bkram_bank_reg #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W), .DATA_W(DATA_W), .BANK_REG_ADDR(BANK_REG_ADDR)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .wr(cpu_wr), .reg_acc(reg_acc),
        .addr(cpu_addr), .wdata(cpu_wdata), .bank(bank_sel)
    );

    bkram_addr_gen #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W), .SHADOW_BANK(SHADOW_BANK),
        .SENSOR_BANK(SENSOR_BANK), .BANK_REG_ADDR(BANK_REG_ADDR)
    ) u_agen (
        .reg_acc(reg_acc), .wr(cpu_wr), .bank(bank_sel), .addr(cpu_addr),
        .ram_addr(ram_addr), .mem_we(mem_we), .sens_wr(sens_wr)
    );

    bkram_mem #(.AW(RAM_AW), .DW(DATA_W)) u_mem (
        .clk(clk), .we(mem_we), .re(cpu_rd), .addr(ram_addr),
        .wdata(cpu_wdata), .q(mem_q)
    );

    // Purpose: choose where the current read is answered from.
    always_comb begin
        if (reg_acc && cpu_addr == BANK_ADDR_L) src_d = SRC_BANK;
        else if (reg_acc && reg_has_rd)         src_d = SRC_EXT;
        else                                    src_d = SRC_RAM;
    end

    // Purpose: capture the read valid flag, the source and the non-RAM data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_vld <= 1'b0;
            src_q     <= SRC_RAM;
            ext_q     <= '0;
            bank_q    <= '0;
        end else begin
            rdata_vld <= cpu_rd;
            if (cpu_rd) begin
                src_q  <= src_d;
                ext_q  <= reg_rdata;
                bank_q <= bank_sel;
            end
        end
    end

    // Purpose: drive the read data from the captured source.
    always_comb begin
        case (src_q)
            SRC_EXT:  cpu_rdata = ext_q;
            SRC_BANK: cpu_rdata = {{(DATA_W-BANK_W){1'b0}}, bank_q};
            default:  cpu_rdata = mem_q;
        endcase
    end

    AST_SHADOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && reg_acc) |-> (ram_addr[RAM_AW-1:ADDR_W] == SHADOW_L)); // R3
    AST_SENS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        sens_wr |-> (bank_sel == SENSOR_L && reg_acc && cpu_wr)); // R7
    AST_RD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rd |=> rdata_vld); // R8
    AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd |=> !rdata_vld); // R8
    AST_DATA_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !reg_acc) |-> (ram_addr[RAM_AW-1:ADDR_W] == bank_sel)); // R2
endmodule

// File: tb/bkram_shadow_tb.sv
// Self-checking bench: directed corner cases, then seeded random traffic,
// all compared against a reference model of the RAM and the bank register.
module bkram_shadow_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam logic [6:0] BANK_ADDR = 7'h7B;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic       cpu_wr = 1'b0, cpu_rd = 1'b0, reg_acc = 1'b0, reg_has_rd = 1'b0;
    logic [7:0] reg_rdata = '0;
    logic [7:0] cpu_rdata;
    logic       rdata_vld;
    logic [9:0] ram_addr;
    logic [2:0] bank_sel;
    logic       sens_wr;

    int         n_run = 0;
    int         n_fail = 0;
    logic [7:0] mem_m [1024];
    logic [2:0] bank_m = '0;
    bit         done = 0;

    bkram_shadow dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .reg_acc(reg_acc), .reg_has_rd(reg_has_rd),
        .reg_rdata(reg_rdata), .cpu_rdata(cpu_rdata), .rdata_vld(rdata_vld),
        .ram_addr(ram_addr), .bank_sel(bank_sel), .sens_wr(sens_wr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [9:0] exp_addr(input logic r, input logic [2:0] b, input logic [6:0] a);
        return r ? {3'd6, a} : {b, a};
    endfunction

    function automatic logic exp_sens(input logic w, input logic r, input logic [2:0] b, input logic [6:0] a);
        return w && r && (b == 3'd0) && (a != BANK_ADDR);
    endfunction

    // One bus cycle: drive at the falling edge, check the combinational
    // outputs, then check the read result just after the sampling edge.
    task automatic cyc(input logic [6:0] a, input logic [7:0] d, input logic w, input logic rd,
                       input logic r, input logic hr, input logic [7:0] ext);
        logic [9:0] ea;
        logic [7:0] er;
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = w; cpu_rd = rd;
        reg_acc = r; reg_has_rd = hr; reg_rdata = ext;
        #1;
        ea = exp_addr(r, bank_m, a);
        check(r ? "R3 ram_addr" : "R2 ram_addr", ram_addr, ea);
        check("R7 sens_wr", sens_wr, exp_sens(w, r, bank_m, a));
        if (r && a == BANK_ADDR)  er = {5'b0, bank_m};
        else if (r && hr)         er = ext;
        else                      er = mem_m[ea];
        @(posedge clk);
        if (w) mem_m[ea] = d;
        if (w && r && a == BANK_ADDR) bank_m = d[2:0];
        #1;
        check("R8 rdata_vld", rdata_vld, rd);
        if (rd) begin
            if (r && a == BANK_ADDR) check("R4 bank readback", cpu_rdata, er);
            else if (r)              check("R6 register read", cpu_rdata, er);
            else                     check("R5 data read", cpu_rdata, er);
        end
        check("R4 bank_sel", bank_sel, bank_m);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check("R1 bank_sel after reset", bank_sel, 3'd0);
        check("R1 rdata_vld after reset", rdata_vld, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // Fill every byte through the data window, bank by bank (R5).
        for (int b = 0; b < 8; b++) begin
            cyc(BANK_ADDR, 8'(b), 1, 0, 1, 0, 8'h00);
            for (int a = 0; a < 128; a++)
                cyc(7'(a), 8'($urandom), 1, 0, 0, 0, 8'h00);
        end

        // R4: the reserved bits are dropped, and the bank reads back zero-extended.
        cyc(BANK_ADDR, 8'hFD, 1, 0, 1, 0, 8'h00);
        cyc(BANK_ADDR, 8'h00, 0, 1, 1, 0, 8'hAA);
        // R5/R3: a register write in bank 5 lands in the shadow bank.
        cyc(7'h10, 8'h5C, 1, 0, 1, 0, 8'h00);
        cyc(7'h10, 8'h00, 0, 1, 1, 0, 8'h00);   // R6 shadow readback
        cyc(7'h10, 8'h00, 0, 1, 1, 1, 8'h3E);   // R6 live register path
        cyc(7'h10, 8'h00, 0, 1, 0, 0, 8'h00);   // bank 5 byte unchanged
        cyc(BANK_ADDR, 8'h06, 1, 0, 1, 0, 8'h00);
        cyc(7'h10, 8'h00, 0, 1, 0, 0, 8'h00);   // shadow seen as data, bank 6
        // R7: the sensor strobe fires in bank 0, but not for the bank register.
        cyc(BANK_ADDR, 8'h00, 1, 0, 1, 0, 8'h00);
        cyc(7'h22, 8'h77, 1, 0, 1, 0, 8'h00);
        cyc(BANK_ADDR, 8'h03, 1, 0, 1, 0, 8'h00);
        cyc(7'h22, 8'h78, 1, 0, 1, 0, 8'h00);
        // R9: read and write in the same cycle return the old state.
        cyc(7'h05, 8'hE1, 1, 1, 0, 0, 8'h00);
        cyc(7'h05, 8'h00, 0, 1, 0, 0, 8'h00);
        cyc(BANK_ADDR, 8'h02, 1, 1, 1, 0, 8'h00);
        cyc(BANK_ADDR, 8'h00, 0, 1, 1, 0, 8'h00);

        // Random traffic, biased toward bank-register hits.
        for (int i = 0; i < 4000; i++) begin
            logic [6:0] a;
            a = ($urandom % 8 == 0) ? BANK_ADDR : 7'($urandom);
            cyc(a, 8'($urandom), 1'($urandom % 3 == 0), 1'($urandom % 2),
                1'($urandom % 2), 1'($urandom % 3 == 0), 8'($urandom));
        end

        @(negedge clk);
        cpu_wr = 0; cpu_rd = 0;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule